// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block turns the two synchronised data lines of a low-speed USB port into a stream of received bytes. The lines are sampled once per clock, with the clock running at `OVS` times the line bit rate. While idle the receiver looks for a falling D- edge that moves the line from J to K. It then follows the alternating sync bits until it sees two K bits in a row, and only then starts to collect packet data.

Bit timing comes from a phase counter. The counter snaps back to the start of a bit whenever D- changes level, and a bit is taken at tick `OVS/2` after the most recent transition. This keeps sampling near the bit centre even when the local clock runs slightly fast or slow. Data bits are NRZI-decoded and stuffed zeros are removed. Bits are packed into bytes least-significant bit first. Each completed byte is presented with a one-clock strobe.

A packet closes normally on two consecutive single-ended-zero bits. It closes abnormally on a missing stuffed zero, on an isolated SE0, or when more bytes arrive than the parameterised capacity allows. After an abnormal close the receiver ignores the line until the next SE0, then hunts again.

Top module: `usb_ls_rx`

## Requirements
- R1: While reset is asserted and after it is released with the line idle (J: dp 0, dm 1), `rx_valid_o`, `rx_eop_o`, `rx_frame_err_o`, `rx_overflow_o`, `rx_stuff_err_o` and `rx_active_o` are all 0.
- R2: K is dp 1, dm 0. After a J-to-K edge, `rx_active_o` rises only once two consecutive bit samples read K (a sync field K J K J K J K K). A K followed by a J sample sends the receiver back to edge hunting, so a line that never shows a double K produces no byte and never raises `rx_active_o`.
- R3: NRZI decoding: a data bit is 1 when dm holds the level of the previous bit and 0 when it changes. The first data bit is compared against the final K of the sync field.
- R4: After six consecutive decoded 1 bits, the following bit is dropped and not placed in any byte.
- R5: Kept bits are packed least-significant bit first. `rx_valid_o` is high for exactly one clock per 8 kept bits, with the byte on `rx_data_o`.
- R6: A 1 where a stuffed 0 is due pulses `rx_stuff_err_o`, drops `rx_active_o`, and yields no further byte and no `rx_eop_o` for that packet.
- R7: Two consecutive bit samples with both lines 0 (SE0) pulse `rx_eop_o` for one clock and drop `rx_active_o`.
- R8: If bits of an unfinished byte are pending when the packet ends by R7, `rx_frame_err_o` pulses in the same clock as `rx_eop_o`. A packet made only of whole bytes gives no `rx_frame_err_o`.
- R9: A single SE0 bit followed by a J or K bit pulses `rx_frame_err_o`, aborts the packet, and gives no `rx_eop_o` for it.
- R10: At most `BUF_BYTES` bytes are delivered per packet. The byte completing after that pulses `rx_overflow_o` instead of `rx_valid_o` and aborts the packet. A packet of exactly `BUF_BYTES` bytes completes normally.
- R11: Packets are received correctly when one bit in every twelve lasts `OVS-1` or `OVS+1` clocks instead of `OVS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, `OVS` times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_i | input | 1 | Synchronised D+ level |
| dm_i | input | 1 | Synchronised D- level |
| rx_data_o | output | BYTE_W | Last received byte |
| rx_valid_o | output | 1 | One-clock strobe for a new byte |
| rx_active_o | output | 1 | High between the end of sync and the end of packet |
| rx_eop_o | output | 1 | One-clock pulse on a normal end of packet |
| rx_frame_err_o | output | 1 | Partial final byte or isolated SE0 |
| rx_overflow_o | output | 1 | Byte capacity exceeded, packet aborted |
| rx_stuff_err_o | output | 1 | Missing stuffed zero, packet aborted |

## Verification
Byte completion and capacity exhaustion fall in the same clock. The receiver must then choose between the data strobe and the overflow pulse, and it must never raise both. The bench provokes this by sending one byte more than `BUF_BYTES`. It then checks that exactly `BUF_BYTES` strobes arrive, that one overflow pulse follows, and that no end-of-packet pulse appears for that packet. A second coincidence, end of packet together with a pending partial byte, is provoked by adding three loose bits before the SE0. That case must give the frame-error and end-of-packet pulses in one clock.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

  typedef enum logic [1:0] {
    RX_HUNT  = 2'd0,
    RX_SYNC  = 2'd1,
    RX_DATA  = 2'd2,
    RX_DRAIN = 2'd3
  } rx_state_e;

  typedef struct packed {
    logic vld;
    logic eop;
    logic frm;
    logic ovf;
    logic stf;
  } rx_evt_t;

  function automatic logic line_is_k(input logic dp, input logic dm);
    return dp & ~dm;
  endfunction

  function automatic logic line_is_se0(input logic dp, input logic dm);
    return ~dp & ~dm;
  endfunction

endpackage

// File: rtl/usbrx_phase_trk.sv
module usbrx_phase_trk #(
  parameter int unsigned OVS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dm_i,
  output logic bit_stb_o,
  output logic dm_fall_o
);
  localparam int unsigned PW = $clog2(OVS);
  localparam logic [PW-1:0] MID  = PW'(OVS / 2);
  localparam logic [PW-1:0] LAST = PW'(OVS - 1);

  logic          dm_prev_q;
  logic [PW-1:0] ph_q, ph_d;
  logic          dm_edge;

  always_comb begin
    dm_edge = dm_i ^ dm_prev_q;
    if (dm_edge)          ph_d = PW'(1);
    else if (ph_q == LAST) ph_d = '0;
    else                  ph_d = ph_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dm_prev_q <= 1'b1;
      ph_q      <= '0;
    end else begin
      dm_prev_q <= dm_i;
      ph_q      <= ph_d;
    end
  end

  assign bit_stb_o = (ph_q == MID) && !dm_edge;
  assign dm_fall_o = dm_prev_q & ~dm_i;

endmodule

// File: rtl/usbrx_nrzi_unstuff.sv
module usbrx_nrzi_unstuff #(
  parameter int unsigned STUFF_RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic en_i,
  input  logic lvl_i,
  output logic bit_o,
  output logic bit_vld_o,
  output logic stuff_err_o
);
  localparam int unsigned CW = $clog2(STUFF_RUN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(STUFF_RUN);

  logic          lvl_prev_q, lvl_prev_d;
  logic [CW-1:0] ones_q, ones_d;
  logic          same_lvl, at_run;

  always_comb begin
    same_lvl    = (lvl_i == lvl_prev_q);
    at_run      = (ones_q == RUN_MAX);
    bit_o       = same_lvl;
    bit_vld_o   = en_i && !at_run;
    stuff_err_o = en_i && at_run && same_lvl;
  end

  always_comb begin
    lvl_prev_d = lvl_prev_q;
    ones_d     = ones_q;
    if (init_i) begin
      lvl_prev_d = 1'b0;
      ones_d     = '0;
    end else if (en_i) begin
      lvl_prev_d = lvl_i;
      if (at_run || !same_lvl) ones_d = '0;
      else                     ones_d = ones_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev_q <= 1'b0;
      ones_q     <= '0;
    end else begin
      lvl_prev_q <= lvl_prev_d;
      ones_q     <= ones_d;
    end
  end

endmodule

// File: rtl/usbrx_byte_asm.sv
module usbrx_byte_asm #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned BUF_BYTES = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              done_o,
  output logic              ovf_o,
  output logic              partial_o
);
  localparam int unsigned IW = $clog2(BYTE_W);
  localparam int unsigned LW = $clog2(BUF_BYTES + 1);
  localparam logic [IW-1:0] TOP_BIT = IW'(BYTE_W - 1);
  localparam logic [LW-1:0] CAP     = LW'(BUF_BYTES);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [IW-1:0]     cnt_q, cnt_d;
  logic [LW-1:0]     left_q, left_d;
  logic              full;

  always_comb begin
    byte_o    = {bit_i, sh_q[BYTE_W-1:1]};
    full      = bit_vld_i && (cnt_q == TOP_BIT);
    done_o    = full && (left_q != '0);
    ovf_o     = full && (left_q == '0);
    partial_o = (cnt_q != '0);
  end

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    left_d = left_q;
    if (init_i) begin
      sh_d   = '0;
      cnt_d  = '0;
      left_d = CAP;
    end else if (bit_vld_i) begin
      sh_d  = byte_o;
      cnt_d = full ? '0 : cnt_q + IW'(1);
      if (done_o) left_d = left_q - LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      left_q <= '0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      left_q <= left_d;
    end
  end

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usbrx_pkg::*;
#(
  parameter int unsigned OVS       = 8,
  parameter int unsigned BUF_BYTES = 11,
  parameter int unsigned STUFF_RUN = 6,
  parameter int unsigned BYTE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dp_i,
  input  logic              dm_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_active_o,
  output logic              rx_eop_o,
  output logic              rx_frame_err_o,
  output logic              rx_overflow_o,
  output logic              rx_stuff_err_o
);

  rx_state_e         state_q, state_d;
  logic              seen_k_q, seen_k_d;
  logic              se0p_q, se0p_d;
  rx_evt_t           evt_q, evt_d;
  logic [BYTE_W-1:0] data_q;

  logic bit_stb, dm_fall;
  logic is_k, is_se0;
  logic dec_init, dec_en;
  logic dbit, dbit_vld, stuff_err;
  logic [BYTE_W-1:0] asm_byte;
  logic asm_done, asm_ovf, asm_partial;

  usbrx_phase_trk #(.OVS(OVS)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .dm_i      (dm_i),
    .bit_stb_o (bit_stb),
    .dm_fall_o (dm_fall)
  );

  usbrx_nrzi_unstuff #(.STUFF_RUN(STUFF_RUN)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_i      (dec_init),
    .en_i        (dec_en),
    .lvl_i       (dm_i),
    .bit_o       (dbit),
    .bit_vld_o   (dbit_vld),
    .stuff_err_o (stuff_err)
  );

  usbrx_byte_asm #(.BYTE_W(BYTE_W), .BUF_BYTES(BUF_BYTES)) u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_i    (dec_init),
    .bit_vld_i (dbit_vld),
    .bit_i     (dbit),
    .byte_o    (asm_byte),
    .done_o    (asm_done),
    .ovf_o     (asm_ovf),
    .partial_o (asm_partial)
  );

  // line classification and datapath enables
  always_comb begin
    is_k     = line_is_k(dp_i, dm_i);
    is_se0   = line_is_se0(dp_i, dm_i);
    dec_init = bit_stb && (state_q == RX_SYNC) && is_k && seen_k_q;
    dec_en   = bit_stb && (state_q == RX_DATA) && !is_se0 && !se0p_q;
  end

  // packet sequencing
  always_comb begin
    state_d  = state_q;
    seen_k_d = seen_k_q;
    se0p_d   = se0p_q;
    evt_d    = '0;
    unique case (state_q)
      RX_HUNT: begin
        if (dm_fall && is_k) begin
          state_d  = RX_SYNC;
          seen_k_d = 1'b0;
        end
      end
      RX_SYNC: begin
        if (bit_stb) begin
          if (!is_k) begin
            state_d = RX_HUNT;
          end else if (seen_k_q) begin
            state_d = RX_DATA;
            se0p_d  = 1'b0;
          end else begin
            seen_k_d = 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (bit_stb) begin
          if (is_se0) begin
            if (se0p_q) begin
              evt_d.eop = 1'b1;
              evt_d.frm = asm_partial;
              se0p_d    = 1'b0;
              state_d   = RX_HUNT;
            end else begin
              se0p_d = 1'b1;
            end
          end else if (se0p_q) begin
            evt_d.frm = 1'b1;
            se0p_d    = 1'b0;
            state_d   = RX_DRAIN;
          end else if (stuff_err) begin
            evt_d.stf = 1'b1;
            state_d   = RX_DRAIN;
          end else if (asm_ovf) begin
            evt_d.ovf = 1'b1;
            state_d   = RX_DRAIN;
          end else if (asm_done) begin
            evt_d.vld = 1'b1;
          end
        end
      end
      RX_DRAIN: begin
        if (is_se0) state_d = RX_HUNT;
      end
      default: state_d = RX_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RX_HUNT;
      seen_k_q <= 1'b0;
      se0p_q   <= 1'b0;
      evt_q    <= '0;
    end else begin
      state_q  <= state_d;
      seen_k_q <= seen_k_d;
      se0p_q   <= se0p_d;
      evt_q    <= evt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (evt_d.vld) begin
      data_q <= asm_byte;
    end
  end

  assign rx_data_o      = data_q;
  assign rx_valid_o     = evt_q.vld;
  assign rx_eop_o       = evt_q.eop;
  assign rx_frame_err_o = evt_q.frm;
  assign rx_overflow_o  = evt_q.ovf;
  assign rx_stuff_err_o = evt_q.stf;
  assign rx_active_o    = (state_q == RX_DATA);

endmodule

// File: rtl/usb_ls_rx_chk.sv
module usb_ls_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_valid_o,
  input logic rx_active_o,
  input logic rx_eop_o,
  input logic rx_frame_err_o,
  input logic rx_overflow_o,
  input logic rx_stuff_err_o
);

  // R5: byte strobe lasts a single clock
  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R5: bytes only appear inside a packet
  a_r5_valid_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> rx_active_o);

  // R10: an overflowing byte is never also delivered
  a_r10_no_valid_with_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow_o |-> !rx_valid_o);

  // R7: end of packet leaves the packet state
  a_r7_eop_closes: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eop_o |-> !rx_active_o);

  // R6: a packet only ends with a reported cause
  a_r6_end_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_active_o) |-> (rx_eop_o || rx_overflow_o || rx_stuff_err_o || rx_frame_err_o));

  // R6: at most one terminating cause at a time
  a_r6_single_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_eop_o, rx_overflow_o, rx_stuff_err_o}));

endmodule

bind usb_ls_rx usb_ls_rx_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rx_valid_o     (rx_valid_o),
  .rx_active_o    (rx_active_o),
  .rx_eop_o       (rx_eop_o),
  .rx_frame_err_o (rx_frame_err_o),
  .rx_overflow_o  (rx_overflow_o),
  .rx_stuff_err_o (rx_stuff_err_o)
);

// File: tb/tb_usb_ls_rx.sv
`timescale 1ns/1ps
module tb_usb_ls_rx;
  localparam int CAP = 11;
  localparam int OVS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp = 1'b0;
  logic dm = 1'b1;
  logic [7:0] rx_data;
  logic rx_valid, rx_active, rx_eop, rx_frm, rx_ovf, rx_stf;

  always #2.5 clk = ~clk;

  usb_ls_rx #(.OVS(OVS), .BUF_BYTES(CAP)) dut (
    .clk(clk), .rst_n(rst_n), .dp_i(dp), .dm_i(dm),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_active_o(rx_active),
    .rx_eop_o(rx_eop), .rx_frame_err_o(rx_frm), .rx_overflow_o(rx_ovf),
    .rx_stuff_err_o(rx_stf)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // monitor-owned counters
  logic [7:0] rxb [0:63];
  int rx_n = 0, eop_n = 0, eopfrm_n = 0, frm_n = 0, ovf_n = 0, stf_n = 0, rise_n = 0;
  logic act_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin rxb[rx_n % 64] = rx_data; rx_n++; end
      if (rx_eop) eop_n++;
      if (rx_eop && rx_frm) eopfrm_n++;
      if (rx_frm) frm_n++;
      if (rx_ovf) ovf_n++;
      if (rx_stf) stf_n++;
      if (rx_active && !act_prev) rise_n++;
      act_prev = rx_active;
    end
  end

  // encoder state
  logic lvl;
  int ones, bitctr, jit;
  bit stuff_en;
  logic [7:0] exp_b [0:63];
  int b_rx, b_eop, b_ef, b_frm, b_ovf, b_stf, b_rise;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic put(input logic p, input logic m);
    int len;
    len = OVS;
    bitctr++;
    if (jit != 0 && (bitctr % 12) == 0) len = OVS + jit;
    dp = p; dm = m;
    repeat (len) @(negedge clk);
  endtask

  task automatic put_lvl(input logic l); put(~l, l); endtask
  task automatic put_se0(); put(1'b0, 1'b0); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) put_lvl(1'b1); endtask

  task automatic sync_seq();
    put_lvl(0); put_lvl(1); put_lvl(0); put_lvl(1);
    put_lvl(0); put_lvl(1); put_lvl(0); put_lvl(0);
    lvl = 1'b0; ones = 0;
  endtask

  task automatic data_bit(input logic b);
    if (b) begin put_lvl(lvl); ones++; end
    else begin lvl = ~lvl; put_lvl(lvl); ones = 0; end
    if (stuff_en && ones == 6) begin lvl = ~lvl; put_lvl(lvl); ones = 0; end
  endtask

  task automatic data_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) data_bit(v[i]);
  endtask

  task automatic eop_seq();
    put_se0(); put_se0(); idle(4);
  endtask

  task automatic snap();
    b_rx = rx_n; b_eop = eop_n; b_ef = eopfrm_n; b_frm = frm_n;
    b_ovf = ovf_n; b_stf = stf_n; b_rise = rise_n;
  endtask

  task automatic send_pkt(input int n);
    idle(3); sync_seq();
    for (int i = 0; i < n; i++) data_byte(exp_b[i]);
    eop_seq();
  endtask

  task automatic check_pkt(input string tag, input int nb, input int e_eop, input int e_ef,
                           input int e_frm, input int e_ovf, input int e_stf);
    chk({tag, " byte count"}, rx_n - b_rx, nb);
    for (int i = 0; i < nb; i++)
      chk({tag, " byte value"}, int'(rxb[(b_rx + i) % 64]), int'(exp_b[i]));
    chk({tag, " eop count"}, eop_n - b_eop, e_eop);
    chk({tag, " eop+frame_err same clock"}, eopfrm_n - b_ef, e_ef);
    chk({tag, " frame_err count"}, frm_n - b_frm, e_frm);
    chk({tag, " overflow count"}, ovf_n - b_ovf, e_ovf);
    chk({tag, " stuff_err count"}, stf_n - b_stf, e_stf);
    chk({tag, " active idle after packet"}, int'(rx_active), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20117);
    lvl = 1'b1; ones = 0; bitctr = 0; jit = 0; stuff_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid in reset", int'(rx_valid), 0);
    chk("R1 active in reset", int'(rx_active), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 flags after reset", int'({rx_valid, rx_eop, rx_frm, rx_ovf, rx_stf}), 0);
    chk("R1 active after reset", int'(rx_active), 0);

    // R2: no double K -> no lock
    snap();
    idle(2); put_lvl(0); put_lvl(1); put_lvl(1); put_lvl(0); put_lvl(1);
    put_lvl(0); put_lvl(1); put_lvl(1); idle(3);
    chk("R2 no active rise without double K", rise_n - b_rise, 0);
    chk("R2 no bytes without double K", rx_n - b_rx, 0);

    // R2: false start then proper sync
    snap();
    exp_b[0] = 8'hC3; exp_b[1] = 8'h5A;
    idle(2); put_lvl(0); put_lvl(1); put_lvl(1);
    sync_seq(); data_byte(exp_b[0]); data_byte(exp_b[1]); eop_seq();
    check_pkt("R2 relock after false K", 2, 1, 0, 0, 0, 0);

    // R3 R5 R7 basic
    snap();
    exp_b[0] = 8'hA5; exp_b[1] = 8'h00; exp_b[2] = 8'h81;
    send_pkt(3);
    check_pkt("R3 R5 R7 basic packet", 3, 1, 0, 0, 0, 0);

    // R4 stuffing
    snap();
    exp_b[0] = 8'hFF; exp_b[1] = 8'hFF; exp_b[2] = 8'h3F; exp_b[3] = 8'h7E; exp_b[4] = 8'hFC;
    send_pkt(5);
    check_pkt("R4 stuffed bits dropped", 5, 1, 0, 0, 0, 0);

    // R6 stuff error, then recovery
    snap();
    exp_b[0] = 8'hA5;
    idle(3); sync_seq(); data_byte(8'hA5);
    stuff_en = 1'b0; data_byte(8'hFF); data_byte(8'h0F); stuff_en = 1'b1;
    eop_seq();
    check_pkt("R6 missing stuffed zero", 1, 0, 0, 0, 0, 1);
    snap();
    exp_b[0] = 8'h42;
    send_pkt(1);
    check_pkt("R6 recovery after stuff error", 1, 1, 0, 0, 0, 0);

    // R8 partial final byte
    snap();
    exp_b[0] = 8'h55;
    idle(3); sync_seq(); data_byte(8'h55); data_bit(1); data_bit(0); data_bit(1);
    eop_seq();
    check_pkt("R8 partial byte at eop", 1, 1, 1, 1, 0, 0);

    // R9 lone SE0
    snap();
    exp_b[0] = 8'h12;
    idle(3); sync_seq(); data_byte(8'h12); put_se0(); put_lvl(lvl);
    data_byte(8'h34); eop_seq();
    check_pkt("R9 isolated SE0 aborts", 1, 0, 0, 1, 0, 0);

    // R10 exactly full, then one too many
    snap();
    for (int i = 0; i < CAP; i++) exp_b[i] = 8'(i * 37 + 5);
    send_pkt(CAP);
    check_pkt("R10 exactly capacity", CAP, 1, 0, 0, 0, 0);
    snap();
    exp_b[CAP] = 8'hEE;
    send_pkt(CAP + 1);
    check_pkt("R10 overflow replaces byte", CAP, 0, 0, 0, 1, 0);
    snap();
    exp_b[0] = 8'h99;
    send_pkt(1);
    check_pkt("R10 recovery after overflow", 1, 1, 0, 0, 0, 0);

    // R11 clock mismatch both ways
    for (int j = -1; j <= 1; j += 2) begin
      jit = j;
      snap();
      exp_b[0] = 8'hFF; exp_b[1] = 8'h00; exp_b[2] = 8'h7F; exp_b[3] = 8'hFE;
      exp_b[4] = 8'h01; exp_b[5] = 8'hFF; exp_b[6] = 8'h80;
      send_pkt(7);
      check_pkt(j < 0 ? "R11 fast line" : "R11 slow line", 7, 1, 0, 0, 0, 0);
    end

    // random packets (R3 R4 R5 R7 R11)
    for (int k = 0; k < 30; k++) begin
      int n;
      n = 1 + int'($urandom % CAP);
      jit = int'($urandom % 3) - 1;
      for (int i = 0; i < n; i++) exp_b[i] = 8'($urandom);
      snap();
      send_pkt(n);
      check_pkt("R5 R11 random packet", n, 1, 0, 0, 0, 0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule